// File: doc/BRIEF.md
# Serial Flash Command Transfer Engine

This block runs one serial-flash transaction at a time on behalf of software. Software fills a small register file with up to five command bytes, a mask choosing which of them go out, an outbound payload length, an inbound byte count and a local memory address. It then writes the start bit. The engine pulls chip select low and shifts the selected command bytes out. After that it streams the payload from local memory to the flash, and then captures the requested number of returned bytes into local memory. When the last memory write has finished, chip select is released and a completion flag is raised. Software polls that flag.

The serial interface is mode 0 (clock idles low, data sampled on the rising edge), most significant bit first, with the serial clock at half the system clock. Local memory is 32 bits wide. A read request returns its data on the following cycle, and byte enables qualify each write. Payload bytes are taken from memory words in little-endian lane order. Captured bytes are packed the same way.

Top module: `sfl_cmd_dma`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and every register, including the completion flag at offset 0x18, reads 0.
- R2: Registers read back what was written. The mask at 0x14 keeps bits [4:0]. The control word at 0x04 keeps bits [27:8] and [6:0], and its start bit 7 reads 0. A write to 0x18 changes nothing.
- R3: Command byte n (0 to 4) is sent if and only if mask bit n is set and n is below the command length in control bits [6:0]. Bytes go out in ascending n. Bytes 0 to 3 are bits [7:0], [15:8], [23:16] and [31:24] of the word at 0x0C, and byte 4 is bits [7:0] of the word at 0x10.
- R4: The serial clock stays low while chip select is high and is never high for two consecutive system cycles. Each byte is sent and received most significant bit first.
- R5: Chip select falls once per transaction and stays low from the first command byte to the last captured byte.
- R6: Control bits [27:8] give a count of payload bytes. These are read from memory starting at the byte address in 0x1C, taken in little-endian lane order, and sent right after the command bytes.
- R7: The count at 0x08 gives the number of bytes clocked in after the payload. They are written to memory from the address in 0x1C upward, packed little-endian, with byte enables covering only the lanes received, so unaligned starts and partial final words leave other lanes untouched. The first returned byte lands in the lowest addressed lane. A count of 0 means no read phase and no memory write.
- R8: The completion flag reads 0 from the cycle after a start and reads 1 only after chip select has risen and all memory writes are done. It stays 1 until the next start.
- R9: A control-register write with the start bit set while a transaction is active is ignored entirely. No second transaction follows, and the stored control value is unchanged.
- R10: Only bits [15:0] of the inbound count are used, which keeps a read below 64 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sck_o | output | 1 | Serial clock |
| csn_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Word-aligned memory byte address |
| mem_be_o | output | 4 | Write byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
The hardest case to reach from the ports is a start attempt that arrives while a transfer is still in flight. It must leave the active transaction, the stored control word and the completion flag untouched. The stimulus starts a long read and writes a conflicting start command part-way through. After completion it confirms three things: the flash saw exactly the first transaction, chip select never fell again, and the control register still holds the first value. Unaligned read destinations are also exercised, so that both the leading and the trailing partial words are written with narrowed byte enables around sentinel data.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int CMD_BYTES = 5;
  localparam int CMD_LEN_W = 7;
  localparam int TX_LEN_W  = 20;
  localparam int RX_LEN_W  = 16;
  localparam int ADDR_W    = 32;
  localparam int REG_AW    = 6;
  localparam int IDX_W     = $clog2(CMD_BYTES + 1);

  localparam logic [REG_AW-1:0] OFS_MODE  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h04;
  localparam logic [REG_AW-1:0] OFS_RXCNT = 6'h08;
  localparam logic [REG_AW-1:0] OFS_BLO   = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_BHI   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_MASK  = 6'h14;
  localparam logic [REG_AW-1:0] OFS_DONE  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_AUX0  = 6'h20;
  localparam logic [REG_AW-1:0] OFS_AUX1  = 6'h24;

  localparam int GO_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_TX, ST_TXW, ST_RX, ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic [8*CMD_BYTES-1:0] cmd;
    logic [CMD_BYTES-1:0]   mask;
    logic [CMD_LEN_W-1:0]   cmd_len;
    logic [TX_LEN_W-1:0]    tx_len;
    logic [RX_LEN_W-1:0]    rx_len;
    logic [ADDR_W-1:0]      addr;
  } xfer_cfg_t;
endpackage

// File: rtl/sfl_regs.sv
module sfl_regs
  import sfl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  output logic              go_o,
  output logic              done_o,
  output xfer_cfg_t         cfg_o
);
  logic [31:0] mode_q, ctrl_q, rxcnt_q, blo_q, bhi_q, addr_q, aux0_q, aux1_q;
  logic [CMD_BYTES-1:0] mask_q;
  logic done_q;
  logic [63:0] both;

  assign go_o = wr_i && (addr_i == OFS_CTRL) && wdata_i[GO_BIT] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; ctrl_q <= '0; rxcnt_q <= '0; blo_q <= '0; bhi_q <= '0;
      addr_q <= '0; aux0_q <= '0; aux1_q <= '0; mask_q <= '0; done_q <= 1'b0;
    end else begin
      if (go_o) done_q <= 1'b0;
      else if (fin_i) done_q <= 1'b1;
      if (wr_i) begin
        unique case (addr_i)
          OFS_MODE:  mode_q  <= wdata_i;
          OFS_CTRL:  if (!busy_i)
                       ctrl_q <= {4'b0, wdata_i[TX_LEN_W+7:8], 1'b0, wdata_i[CMD_LEN_W-1:0]};
          OFS_RXCNT: rxcnt_q <= wdata_i;
          OFS_BLO:   blo_q   <= wdata_i;
          OFS_BHI:   bhi_q   <= wdata_i;
          OFS_MASK:  mask_q  <= wdata_i[CMD_BYTES-1:0];
          OFS_ADDR:  addr_q  <= wdata_i;
          OFS_AUX0:  aux0_q  <= wdata_i;
          OFS_AUX1:  aux1_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_MODE:  rdata_o = mode_q;
      OFS_CTRL:  rdata_o = ctrl_q;
      OFS_RXCNT: rdata_o = rxcnt_q;
      OFS_BLO:   rdata_o = blo_q;
      OFS_BHI:   rdata_o = bhi_q;
      OFS_MASK:  rdata_o = {{(32-CMD_BYTES){1'b0}}, mask_q};
      OFS_DONE:  rdata_o = {31'b0, done_q};
      OFS_ADDR:  rdata_o = addr_q;
      OFS_AUX0:  rdata_o = aux0_q;
      OFS_AUX1:  rdata_o = aux1_q;
      default:   rdata_o = '0;
    endcase
  end

  // length fields come straight from the start write; the rest from storage
  assign both           = {bhi_q, blo_q};
  assign cfg_o.cmd      = both[8*CMD_BYTES-1:0];
  assign cfg_o.mask     = mask_q;
  assign cfg_o.cmd_len  = wdata_i[CMD_LEN_W-1:0];
  assign cfg_o.tx_len   = wdata_i[TX_LEN_W+7:8];
  assign cfg_o.rx_len   = rxcnt_q[RX_LEN_W-1:0];
  assign cfg_o.addr     = addr_q[ADDR_W-1:0];
  assign done_o         = done_q;

  logic unused_ok;
  assign unused_ok = ^{wdata_i[31:TX_LEN_W+8], rxcnt_q[31:RX_LEN_W]};
endmodule

// File: rtl/sfl_shift.sv
module sfl_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic [7:0] sh_q;
  logic [2:0] cnt_q;
  logic       ph_q, busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; cnt_q <= '0; ph_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        sh_q   <= tx_i;
        cnt_q  <= '0;
        ph_q   <= 1'b0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          // sample at the end of the high phase, shift the next bit out
          ph_q  <= 1'b0;
          sh_q  <= {sh_q[6:0], miso_i};
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = sh_q;
  assign sck_o  = busy_q & ph_q;
  assign mosi_o = sh_q[7];
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  xfer_cfg_t         cfg_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              csn_o,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  seq_st_e              st_q;
  xfer_cfg_t            cfg_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 inflight_q, have_q;
  logic [ADDR_W-1:0]    baddr_q;
  logic [TX_LEN_W-1:0]  tx_rem_q;
  logic [RX_LEN_W-1:0]  rx_rem_q;
  logic [31:0]          word_q, acc_q, rx_word;
  logic [3:0]           be_q, rx_be;
  logic [1:0]           lane;
  logic                 cur_en, rx_flush, idx_end;
  logic [7:0]           cur_byte;

  assign lane    = baddr_q[1:0];
  assign idx_end = (idx_q >= IDX_W'(CMD_BYTES));

  always_comb begin
    cur_en   = 1'b0;
    cur_byte = '0;
    for (int i = 0; i < CMD_BYTES; i++) begin
      if (idx_q == IDX_W'(i)) begin
        cur_en   = cfg_q.mask[i] && (i < int'(cfg_q.cmd_len));
        cur_byte = cfg_q.cmd[i*8 +: 8];
      end
    end
  end

  always_comb begin
    rx_word = acc_q;
    rx_word[{lane, 3'b000} +: 8] = sh_rx_i;
    rx_be   = be_q | (4'b0001 << lane);
  end

  assign rx_flush = (lane == 2'd3) || (rx_rem_q == RX_LEN_W'(1));

  always_comb begin
    sh_start_o  = 1'b0;
    sh_tx_o     = '0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {baddr_q[ADDR_W-1:2], 2'b00};
    mem_be_o    = '0;
    mem_wdata_o = rx_word;
    unique case (st_q)
      ST_CMD: if (!inflight_q && !idx_end && cur_en) begin
        sh_start_o = 1'b1;
        sh_tx_o    = cur_byte;
      end
      ST_TX: if (!inflight_q && tx_rem_q != '0) begin
        if (have_q) begin
          sh_start_o = 1'b1;
          sh_tx_o    = word_q[{lane, 3'b000} +: 8];
        end else begin
          mem_req_o = 1'b1;
        end
      end
      ST_RX: begin
        if (inflight_q && sh_done_i && rx_flush) begin
          mem_req_o = 1'b1;
          mem_we_o  = 1'b1;
          mem_be_o  = rx_be;
        end
        if (!inflight_q && rx_rem_q != '0) sh_start_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cfg_q <= '0; idx_q <= '0; inflight_q <= 1'b0;
      have_q <= 1'b0; baddr_q <= '0; tx_rem_q <= '0; rx_rem_q <= '0;
      word_q <= '0; acc_q <= '0; be_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          cfg_q      <= cfg_i;
          idx_q      <= '0;
          inflight_q <= 1'b0;
          have_q     <= 1'b0;
          baddr_q    <= cfg_i.addr;
          tx_rem_q   <= cfg_i.tx_len;
          rx_rem_q   <= cfg_i.rx_len;
          acc_q      <= '0;
          be_q       <= '0;
          st_q       <= ST_CMD;
        end
        ST_CMD: begin
          if (inflight_q) begin
            if (sh_done_i) begin
              inflight_q <= 1'b0;
              idx_q      <= idx_q + 1'b1;
            end
          end else if (idx_end) st_q <= ST_TX;
          else if (cur_en)      inflight_q <= 1'b1;
          else                  idx_q <= idx_q + 1'b1;
        end
        ST_TX: begin
          if (inflight_q) begin
            if (sh_done_i) begin
              inflight_q <= 1'b0;
              tx_rem_q   <= tx_rem_q - 1'b1;
              baddr_q    <= baddr_q + 1'b1;
              if (lane == 2'd3) have_q <= 1'b0;
            end
          end else if (tx_rem_q == '0) begin
            baddr_q <= cfg_q.addr;
            st_q    <= ST_RX;
          end else if (have_q) inflight_q <= 1'b1;
          else                 st_q <= ST_TXW;
        end
        ST_TXW: begin
          word_q <= mem_rdata_i;
          have_q <= 1'b1;
          st_q   <= ST_TX;
        end
        ST_RX: begin
          if (inflight_q) begin
            if (sh_done_i) begin
              inflight_q <= 1'b0;
              rx_rem_q   <= rx_rem_q - 1'b1;
              baddr_q    <= baddr_q + 1'b1;
              if (rx_flush) begin
                acc_q <= '0;
                be_q  <= '0;
              end else begin
                acc_q <= rx_word;
                be_q  <= rx_be;
              end
            end
          end else if (rx_rem_q == '0) st_q <= ST_FIN;
          else inflight_q <= 1'b1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign fin_o  = (st_q == ST_FIN);
  assign csn_o  = (st_q == ST_IDLE) || (st_q == ST_FIN);
endmodule

// File: rtl/sfl_cmd_dma.sv
module sfl_cmd_dma
  import sfl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sck_o,
  output logic              csn_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  xfer_cfg_t  cfg;
  logic       go, busy, fin, done_flag;
  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx;

  sfl_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .fin_i(fin), .go_o(go), .done_o(done_flag), .cfg_o(cfg)
  );

  sfl_seq u_seq (
    .clk_i, .rst_ni,
    .go_i(go), .cfg_i(cfg), .busy_o(busy), .fin_o(fin), .csn_o(csn_o),
    .sh_start_o(sh_start), .sh_tx_o(sh_tx), .sh_done_i(sh_done), .sh_rx_i(sh_rx),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_rdata_i
  );

  sfl_shift u_shift (
    .clk_i, .rst_ni,
    .start_i(sh_start), .tx_i(sh_tx), .busy_o(sh_busy), .done_o(sh_done), .rx_o(sh_rx),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  logic unused_ok;
  assign unused_ok = sh_busy;
endmodule

// File: rtl/sfl_cmd_dma_chk.sv
module sfl_cmd_dma_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       csn_o,
  input logic       sck_o,
  input logic       mem_req_o,
  input logic       mem_we_o,
  input logic [3:0] mem_be_o,
  input logic       done_flag
);
  a_r4_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_o |-> !sck_o);

  a_r4_sck_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);

  a_r7_write_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (!csn_o && mem_be_o != 4'b0000));

  a_r8_done_low_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csn_o |-> !done_flag);

  a_r5_done_after_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csn_o) |=> done_flag);
endmodule

bind sfl_cmd_dma sfl_cmd_dma_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_o(csn_o), .sck_o(sck_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
  .done_flag(done_flag)
);

// File: tb/tb_sfl_cmd_dma.sv
module tb_sfl_cmd_dma;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sck, csn, mosi, miso = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  sfl_cmd_dma dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sck_o(sck), .csn_o(csn), .mosi_o(mosi), .miso_i(miso),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // local memory, one-cycle read latency
  logic [31:0] mem [0:255];
  int wr_count = 0;
  always @(posedge clk) if (mem_req) begin
    if (mem_we) begin
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      wr_count <= wr_count + 1;
    end else mem_rdata <= mem[mem_addr[9:2]];
  end

  // flash responder: byte k of every transaction is fb(k)
  function automatic logic [7:0] fb(int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction

  int sl_bit = 0, last_bytes = 0, cs_rises = 0, hi_run_err = 0;
  logic [7:0] sh_in = '0;
  logic [7:0] cap [0:63];
  always @(posedge sck or posedge csn) begin
    if (csn) begin
      last_bytes = sl_bit / 8;
      sl_bit = 0;
      cs_rises++;
    end else begin
      sh_in = {sh_in[6:0], mosi};
      if (sl_bit % 8 == 7 && sl_bit / 8 < 64) cap[sl_bit/8] = sh_in;
      sl_bit++;
    end
  end
  always @(negedge sck or negedge csn) begin
    logic [7:0] b;
    b = fb(sl_bit / 8);
    miso <= b[7 - (sl_bit % 8)];
  end

  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    if (sck && sck_prev) hi_run_err++;
    sck_prev <= sck;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 8000; i++) begin
      rd(6'h18, d);
      if (d[0]) return;
    end
    check(1'b0, "R8 timeout", d, 32'h1);
  endtask

  task automatic setup(logic [31:0] blo, logic [31:0] bhi, logic [4:0] mask,
                       logic [31:0] rxc, logic [31:0] addr);
    wr(6'h0C, blo); wr(6'h10, bhi); wr(6'h14, {27'b0, mask});
    wr(6'h08, rxc); wr(6'h1C, addr);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(csn === 1'b1, "R1 csn", {31'b0, csn}, 32'h1);
    check(sck === 1'b0, "R1 sck", {31'b0, sck}, 32'h0);
    rd(6'h18, d); check(d == 0, "R1 done", d, 0);
    rd(6'h0C, d); check(d == 0, "R1 buf", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(6'h0C, 32'hA1B2C3D4); rd(6'h0C, d); check(d == 32'hA1B2C3D4, "R2 blo", d, 32'hA1B2C3D4);
    wr(6'h14, 32'hFFFFFFFF); rd(6'h14, d); check(d == 32'h1F, "R2 mask", d, 32'h1F);
    wr(6'h24, 32'h5A5A0001); rd(6'h24, d); check(d == 32'h5A5A0001, "R2 aux", d, 32'h5A5A0001);
    wr(6'h04, 32'hF123457F & ~32'h80); rd(6'h04, d);
    check(d == 32'h0123457F, "R2 ctrl", d, 32'h0123457F);
    check(csn === 1'b1, "R2 no start", {31'b0, csn}, 32'h1);
    wr(6'h18, 32'h1); rd(6'h18, d); check(d == 0, "R2 done ro", d, 0);
  endtask

  task automatic t_opcode_only();
    int w0, r0;
    logic [31:0] d;
    setup(32'h44332205, 32'h0, 5'h01, 0, 32'h0);
    w0 = wr_count; r0 = cs_rises;
    wr(6'h04, 32'h81);
    rd(6'h18, d); check(d == 0, "R8 cleared on start", d, 0);
    wait_done();
    check(last_bytes == 1, "R3 one byte", last_bytes, 1);
    check(cap[0] == 8'h05, "R4 msb first", {24'b0, cap[0]}, 32'h05);
    check(wr_count == w0, "R7 zero count no write", wr_count - w0, 0);
    check(cs_rises == r0 + 1, "R5 single cs", cs_rises - r0, 1);
    repeat (5) @(negedge clk);
    rd(6'h18, d); check(d == 1, "R8 done stays", d, 1);
  endtask

  task automatic t_status_read();
    logic [31:0] exp;
    mem[16] = 32'hDEADBEEF;
    setup(32'h00000005, 32'h0, 5'h01, 4, 32'h40);
    wr(6'h04, 32'h81); wait_done();
    exp = {fb(4), fb(3), fb(2), fb(1)};
    check(mem[16] == exp, "R7 status word", mem[16], exp);
    check(last_bytes == 5, "R7 bytes clocked", last_bytes, 5);
  endtask

  task automatic t_unaligned_read();
    logic [31:0] e0, e1;
    mem[32] = 32'h11111111; mem[33] = 32'h22222222; mem[34] = 32'h33333333;
    setup(32'hCCBBAA0B, 32'h000000A5, 5'h1F, 6, 32'h81);
    wr(6'h04, 32'h85); wait_done();
    check(cap[0] == 8'h0B && cap[1] == 8'hAA && cap[2] == 8'hBB && cap[3] == 8'hCC && cap[4] == 8'hA5,
          "R3 five bytes order", {cap[1], cap[2], cap[3], cap[4]}, 32'hAABBCCA5);
    e0 = {fb(7), fb(6), fb(5), 8'h11};
    e1 = {8'h22, fb(10), fb(9), fb(8)};
    check(mem[32] == e0, "R7 head partial", mem[32], e0);
    check(mem[33] == e1, "R7 tail partial", mem[33], e1);
    check(mem[34] == 32'h33333333, "R7 untouched", mem[34], 32'h33333333);
  endtask

  task automatic t_mask_gaps();
    setup(32'h44332211, 32'h00000055, 5'h0B, 0, 32'h0);
    wr(6'h04, 32'h85); wait_done();
    check(last_bytes == 3 && cap[0] == 8'h11 && cap[1] == 8'h22 && cap[2] == 8'h44,
          "R3 mask gap", {8'(last_bytes), cap[0], cap[1], cap[2]}, 32'h03112244);
    setup(32'h44332211, 32'h00000055, 5'h1F, 0, 32'h0);
    wr(6'h04, 32'h83); wait_done();
    check(last_bytes == 3 && cap[2] == 8'h33, "R3 length limit",
          {8'(last_bytes), 16'h0, cap[2]}, 32'h03000033);
  endtask

  task automatic t_program();
    int w0;
    mem[64] = 32'h44332211; mem[65] = 32'h88776655;
    setup(32'h00100002, 32'h0, 5'h0F, 0, 32'h100);
    w0 = wr_count;
    wr(6'h04, {4'h0, 20'd6, 8'h84}); wait_done();
    check(last_bytes == 10, "R6 byte count", last_bytes, 10);
    check(cap[0] == 8'h02 && cap[3] == 8'h00, "R6 command first", {cap[0], cap[3]}, 16'h0200);
    for (int i = 0; i < 6; i++)
      check(cap[4+i] == 8'(8'h11 * (i + 1)), "R6 payload lane order", cap[4+i], 8'(8'h11 * (i + 1)));
    check(wr_count == w0, "R6 no write", wr_count - w0, 0);
    check(hi_run_err == 0, "R4 sck half rate", hi_run_err, 0);
  endtask

  task automatic t_busy_start();
    int r0;
    logic [31:0] d;
    setup(32'h00000003, 32'h0, 5'h01, 8, 32'h200);
    r0 = cs_rises;
    wr(6'h04, 32'h81);
    repeat (20) @(negedge clk);
    wr(6'h04, 32'h00000283);
    rd(6'h18, d); check(d == 0, "R8 low mid transfer", d, 0);
    wait_done();
    check(last_bytes == 9, "R9 first txn intact", last_bytes, 9);
    repeat (60) @(negedge clk);
    check(cs_rises == r0 + 1 && csn === 1'b1, "R9 no second txn", cs_rises - r0, 1);
    rd(6'h04, d); check(d == 32'h1, "R9 ctrl unchanged", d, 32'h1);
  endtask

  task automatic t_count_width();
    logic [31:0] e;
    mem[160] = 32'h0; mem[161] = 32'h99999999;
    setup(32'h0000009F, 32'h0, 5'h01, 32'h00010003, 32'h280);
    wr(6'h04, 32'h81); wait_done();
    e = {8'h00, fb(3), fb(2), fb(1)};
    check(mem[160] == e && last_bytes == 4, "R10 low bits only", mem[160], e);
    check(mem[161] == 32'h99999999, "R10 no overrun", mem[161], 32'h99999999);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_opcode_only();
    t_status_read();
    t_unaligned_read();
    t_mask_gaps();
    t_program();
    t_busy_start();
    t_count_width();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule